// File: doc/BRIEF.md
# Counting Three-Valued Gate Evaluator

This block evaluates a bank of multi-input gates in three-valued logic (zero, one, unknown) for a hardware logic-simulation engine. It never stores the individual input values of a gate. Each gate keeps two running counts instead: how many of its inputs currently sit at the gate's controlling value, and how many are unknown. A gate's type is set by two bits, a controlling value and an inversion bit. Together these describe AND, OR, NAND and NOR.

The caller reports each input change as an event that names the gate and gives the input's previous and new values. On the clock edge that takes the event, the block adjusts that gate's counts and derives the new output from them. One cycle later it returns the output, a flag that says whether the output moved, and a flag for an illegal event. The caller uses the changed flag to decide whether the gate's fanout needs to be scheduled.

Writing a gate's type re-initialises that gate. All of its inputs are then taken as unknown, which is also the state of every gate after reset.

Top module: `tv3_gate_counter`

## Requirements
- R1: After reset every gate is an AND gate (controlling value 0, no inversion), all of its inputs count as unknown, its registered output is unknown, and res_valid is low.
- R2: The gate type is set by the controlling value c and the inversion bit i: c=0 i=0 is AND, c=1 i=0 is OR, c=0 i=1 is NAND, c=1 i=1 is NOR. When at least one input is at c, the output is c XOR i.
- R3: When no input is at c and at least one input is unknown, the output is unknown (code 2'b10).
- R4: When no input is at c and no input is unknown, the output is (NOT c) XOR i.
- R5: Each event removes the old value from the counts and adds the new value: a count of c goes down when the old value is c and up when the new value is c, and the unknown count behaves the same way for unknown. An event whose old value equals its new value leaves both counts unchanged and reports changed low.
- R6: Values are coded as 2'b00 for 0, 2'b01 for 1 and 2'b10 for unknown. An event whose old or new value is 2'b11, or that names a gate index of NUM_GATES or more, is illegal. It reports res_illegal high and res_changed low, returns the gate's last output as res_value, and leaves the gate's state untouched.
- R7: res_changed is high exactly when the newly evaluated output differs from that gate's previously registered output.
- R8: Every accepted event produces exactly one result, on the clock edge after the edge that samples it, and res_gate carries the event's gate index. No result appears in a cycle that follows one without an accepted event.
- R9: A type write to a gate loads the new c and i, sets all of that gate's inputs to unknown, and sets its output to unknown. An event to the same gate in the same cycle is dropped and gives no result.
- R10: Gates are independent. An event or a type write to one gate does not change the state or output of any other gate, even when the two happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write gate type and re-initialise the gate |
| cfg_gate | input | GW | Gate index for the type write |
| cfg_ctrl | input | 1 | Controlling value c |
| cfg_inv | input | 1 | Inversion bit i |
| ev_valid | input | 1 | An input-change event is present |
| ev_gate | input | GW | Gate index of the event |
| ev_old | input | 2 | Previous value of the changing input |
| ev_new | input | 2 | New value of the changing input |
| res_valid | output | 1 | A result is present |
| res_gate | output | GW | Gate index of the result |
| res_value | output | 2 | Evaluated output of the gate |
| res_changed | output | 1 | Output differs from the previous output |
| res_illegal | output | 1 | The event was illegal and was not applied |

## Verification
The assertions rely on the caller being truthful: the old value in every event must be the value that input really held. Under that assumption a gate's two counts can never add up to more than its fan-in and can never underflow. The bench meets it by keeping its own copy of every pin of every gate. It takes each event's old value from that copy, including for events whose old and new values are equal. It builds illegal events only from the 2'b11 code and leaves its copy untouched when it sends them. Expected outputs come from scanning that pin copy, a method that has nothing in common with the counting logic.

// File: rtl/tv3_pkg.sv
package tv3_pkg;

   typedef logic [1:0] tv_t;

   localparam tv_t TV_ZERO = 2'b00;
   localparam tv_t TV_ONE  = 2'b01;
   localparam tv_t TV_UNK  = 2'b10;
   localparam tv_t TV_BAD  = 2'b11;

   function automatic tv_t tv_of_bit(input logic b);
      return b ? TV_ONE : TV_ZERO;
   endfunction

   function automatic logic tv_is_code_bad(input tv_t v);
      return v == TV_BAD;
   endfunction

endpackage

// File: rtl/tv3_delta.sv
module tv3_delta
   import tv3_pkg::*;
(
   input  logic ctrl,
   input  tv_t  old_v,
   input  tv_t  new_v,
   output logic c_inc,
   output logic c_dec,
   output logic u_inc,
   output logic u_dec,
   output logic code_bad
);

   logic old_is_c, new_is_c, old_is_u, new_is_u, moves;

   always_comb begin
      code_bad = tv_is_code_bad(old_v) || tv_is_code_bad(new_v);
      moves    = !code_bad && (old_v != new_v);
      old_is_c = old_v == tv_of_bit(ctrl);
      new_is_c = new_v == tv_of_bit(ctrl);
      old_is_u = old_v == TV_UNK;
      new_is_u = new_v == TV_UNK;
      c_inc    = moves && new_is_c;
      c_dec    = moves && old_is_c;
      u_inc    = moves && new_is_u;
      u_dec    = moves && old_is_u;
   end

endmodule

// File: rtl/tv3_eval.sv
module tv3_eval
   import tv3_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic          ctrl,
   input  logic          inv,
   input  logic [CW-1:0] ctrl_cnt,
   input  logic [CW-1:0] unk_cnt,
   output tv_t           out_v
);

   always_comb begin
      if (ctrl_cnt != '0)
         out_v = tv_of_bit(ctrl ^ inv);
      else if (unk_cnt != '0)
         out_v = TV_UNK;
      else
         out_v = tv_of_bit(~ctrl ^ inv);
   end

endmodule

// File: rtl/tv3_gate_slot.sv
module tv3_gate_slot
   import tv3_pkg::*;
#(
   parameter int FANIN = 8,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_hit,
   input  logic          cfg_ctrl,
   input  logic          cfg_inv,
   input  logic          upd_hit,
   input  logic [CW-1:0] cc_next,
   input  logic [CW-1:0] cu_next,
   input  tv_t           out_next,
   output logic          ctrl_o,
   output logic          inv_o,
   output logic [CW-1:0] cc_o,
   output logic [CW-1:0] cu_o,
   output tv_t           last_o
);

   localparam logic [CW-1:0] ALL_UNK = CW'(FANIN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_o <= 1'b0;
         inv_o  <= 1'b0;
         cc_o   <= '0;
         cu_o   <= ALL_UNK;
         last_o <= TV_UNK;
      end else if (cfg_hit) begin
         ctrl_o <= cfg_ctrl;
         inv_o  <= cfg_inv;
         cc_o   <= '0;
         cu_o   <= ALL_UNK;
         last_o <= TV_UNK;
      end else if (upd_hit) begin
         cc_o   <= cc_next;
         cu_o   <= cu_next;
         last_o <= out_next;
      end
   end

endmodule

// File: rtl/tv3_gate_counter.sv
module tv3_gate_counter
   import tv3_pkg::*;
#(
   parameter  int FANIN     = 8,
   parameter  int NUM_GATES = 4,
   localparam int CW        = $clog2(FANIN + 1),
   localparam int GW        = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [GW-1:0] cfg_gate,
   input  logic          cfg_ctrl,
   input  logic          cfg_inv,
   input  logic          ev_valid,
   input  logic [GW-1:0] ev_gate,
   input  logic [1:0]    ev_old,
   input  logic [1:0]    ev_new,
   output logic          res_valid,
   output logic [GW-1:0] res_gate,
   output logic [1:0]    res_value,
   output logic          res_changed,
   output logic          res_illegal
);

   generate
      if (FANIN < 1 || FANIN > 16) begin : g_bad_fanin
         $error("tv3_gate_counter: FANIN must lie in 1..16");
      end
      if (NUM_GATES < 1) begin : g_bad_gates
         $error("tv3_gate_counter: NUM_GATES must be at least 1");
      end
   endgenerate

   logic          slot_ctrl [NUM_GATES];
   logic          slot_inv  [NUM_GATES];
   logic [CW-1:0] slot_cc   [NUM_GATES];
   logic [CW-1:0] slot_cu   [NUM_GATES];
   tv_t           slot_last [NUM_GATES];

   logic          sel_ctrl, sel_inv, gate_ok;
   logic [CW-1:0] sel_cc, sel_cu, cc_next, cu_next;
   tv_t           sel_last, out_next;
   logic          c_inc, c_dec, u_inc, u_dec, code_bad;
   logic          conflict, accept, bad, upd_en;

   always_comb begin
      sel_ctrl = 1'b0;
      sel_inv  = 1'b0;
      sel_cc   = '0;
      sel_cu   = '0;
      sel_last = TV_UNK;
      gate_ok  = 1'b0;
      for (int g = 0; g < NUM_GATES; g++) begin
         if (ev_gate == GW'(g)) begin
            sel_ctrl = slot_ctrl[g];
            sel_inv  = slot_inv[g];
            sel_cc   = slot_cc[g];
            sel_cu   = slot_cu[g];
            sel_last = slot_last[g];
            gate_ok  = 1'b1;
         end
      end
   end

   tv3_delta u_delta (
      .ctrl     (sel_ctrl),
      .old_v    (ev_old),
      .new_v    (ev_new),
      .c_inc    (c_inc),
      .c_dec    (c_dec),
      .u_inc    (u_inc),
      .u_dec    (u_dec),
      .code_bad (code_bad)
   );

   always_comb begin
      cc_next = sel_cc + CW'(c_inc) - CW'(c_dec);
      cu_next = sel_cu + CW'(u_inc) - CW'(u_dec);
   end

   tv3_eval #(.CW(CW)) u_eval (
      .ctrl     (sel_ctrl),
      .inv      (sel_inv),
      .ctrl_cnt (cc_next),
      .unk_cnt  (cu_next),
      .out_v    (out_next)
   );

   always_comb begin
      conflict = cfg_we && (cfg_gate == ev_gate);
      accept   = ev_valid && !conflict;
      bad      = code_bad || !gate_ok;
      upd_en   = accept && !bad;
   end

   generate
      for (genvar g = 0; g < NUM_GATES; g++) begin : g_slot
         tv3_gate_slot #(.FANIN(FANIN), .CW(CW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_hit  (cfg_we && (cfg_gate == GW'(g))),
            .cfg_ctrl (cfg_ctrl),
            .cfg_inv  (cfg_inv),
            .upd_hit  (upd_en && (ev_gate == GW'(g))),
            .cc_next  (cc_next),
            .cu_next  (cu_next),
            .out_next (out_next),
            .ctrl_o   (slot_ctrl[g]),
            .inv_o    (slot_inv[g]),
            .cc_o     (slot_cc[g]),
            .cu_o     (slot_cu[g]),
            .last_o   (slot_last[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_gate    <= '0;
         res_value   <= TV_UNK;
         res_changed <= 1'b0;
         res_illegal <= 1'b0;
      end else begin
         res_valid <= accept;
         if (accept) begin
            res_gate    <= ev_gate;
            res_illegal <= bad;
            res_value   <= bad ? sel_last : out_next;
            res_changed <= !bad && (out_next != sel_last);
         end
      end
   end

endmodule

// File: rtl/tv3_gate_counter_chk.sv
module tv3_gate_counter_chk #(
   parameter int FANIN = 8,
   parameter int CW    = 4,
   parameter int GW    = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic [GW-1:0] cfg_gate,
   input logic          ev_valid,
   input logic [GW-1:0] ev_gate,
   input logic [1:0]    ev_old,
   input logic [1:0]    ev_new,
   input logic          res_valid,
   input logic [1:0]    res_value,
   input logic          res_changed,
   input logic          res_illegal,
   input logic [CW-1:0] sel_cc,
   input logic [CW-1:0] sel_cu
);

   AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !(cfg_we && cfg_gate == ev_gate)) |=> res_valid); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> !res_valid); // R8

   AST_CFG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && cfg_we && cfg_gate == ev_gate) |=> !res_valid); // R9

   AST_BAD_CODE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !(cfg_we && cfg_gate == ev_gate) &&
       (ev_old == 2'b11 || ev_new == 2'b11)) |=> (res_valid && res_illegal)); // R6

   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_illegal) |-> !res_changed); // R6

   AST_VALUE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_value != 2'b11)); // R6

   AST_SAME_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !(cfg_we && cfg_gate == ev_gate) && ev_old == ev_new)
      |=> !res_changed); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, sel_cc} + {1'b0, sel_cu}) <= (CW + 1)'(FANIN)); // R5

endmodule

bind tv3_gate_counter tv3_gate_counter_chk #(.FANIN(FANIN), .CW(CW), .GW(GW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_gate    (cfg_gate),
   .ev_valid    (ev_valid),
   .ev_gate     (ev_gate),
   .ev_old      (ev_old),
   .ev_new      (ev_new),
   .res_valid   (res_valid),
   .res_value   (res_value),
   .res_changed (res_changed),
   .res_illegal (res_illegal),
   .sel_cc      (sel_cc),
   .sel_cu      (sel_cu)
);

// File: tb/tv3_gate_counter_test.sv
`timescale 1ns/1ps
module tv3_gate_counter_test;

   localparam int FI = 8;
   localparam int NG = 4;
   localparam int GW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [GW-1:0] cfg_gate = '0;
   logic          cfg_ctrl = 1'b0;
   logic          cfg_inv = 1'b0;
   logic          ev_valid = 1'b0;
   logic [GW-1:0] ev_gate = '0;
   logic [1:0]    ev_old = 2'b00;
   logic [1:0]    ev_new = 2'b00;
   logic          res_valid;
   logic [GW-1:0] res_gate;
   logic [1:0]    res_value;
   logic          res_changed;
   logic          res_illegal;

   always #2 clk = ~clk;

   tv3_gate_counter #(.FANIN(FI), .NUM_GATES(NG)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_gate(cfg_gate), .cfg_ctrl(cfg_ctrl), .cfg_inv(cfg_inv),
      .ev_valid(ev_valid), .ev_gate(ev_gate), .ev_old(ev_old), .ev_new(ev_new),
      .res_valid(res_valid), .res_gate(res_gate), .res_value(res_value),
      .res_changed(res_changed), .res_illegal(res_illegal)
   );

   typedef struct packed {
      logic [GW-1:0] g;
      logic [1:0]    v;
      logic          ch;
      logic          il;
   } exp_t;

   exp_t  expq[$];
   string tagq[$];

   logic [1:0] pins [NG][FI];
   logic       mc   [NG];
   logic       mi   [NG];
   logic [1:0] mlast[NG];

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   function automatic logic [1:0] model_out(int g);
      bit any_c = 0;
      bit any_u = 0;
      for (int p = 0; p < FI; p++) begin
         if (pins[g][p] == {1'b0, mc[g]}) any_c = 1;
         if (pins[g][p] == 2'b10) any_u = 1;
      end
      if (any_c) return {1'b0, mc[g] ^ mi[g]};
      if (any_u) return 2'b10;
      return {1'b0, ~mc[g] ^ mi[g]};
   endfunction

   task automatic model_init(int g, logic c, logic i);
      for (int p = 0; p < FI; p++) pins[g][p] = 2'b10;
      mc[g] = c;
      mi[g] = i;
      mlast[g] = 2'b10;
   endtask

   task automatic push_exp(int g, logic [1:0] v, logic ch, logic il, string tag);
      exp_t e;
      e.g = GW'(g);
      e.v = v;
      e.ch = ch;
      e.il = il;
      expq.push_back(e);
      tagq.push_back(tag);
   endtask

   // Drives one legal event at a negative edge and leaves it asserted.
   task automatic send_ev(int g, int p, logic [1:0] nv, string tag);
      logic [1:0] ov;
      logic [1:0] e;
      @(negedge clk);
      cfg_we = 1'b0;
      ov = pins[g][p];
      ev_valid = 1'b1;
      ev_gate = GW'(g);
      ev_old = ov;
      ev_new = nv;
      pins[g][p] = nv;
      e = model_out(g);
      push_exp(g, e, e != mlast[g], 1'b0, tag);
      mlast[g] = e;
   endtask

   task automatic send_bad(int g, logic [1:0] ov, logic [1:0] nv, string tag);
      @(negedge clk);
      cfg_we = 1'b0;
      ev_valid = 1'b1;
      ev_gate = GW'(g);
      ev_old = ov;
      ev_new = nv;
      push_exp(g, mlast[g], 1'b0, 1'b1, tag);
   endtask

   task automatic do_cfg(int g, logic c, logic i);
      @(negedge clk);
      ev_valid = 1'b0;
      cfg_we = 1'b1;
      cfg_gate = GW'(g);
      cfg_ctrl = c;
      cfg_inv = i;
      model_init(g, c, i);
   endtask

   // Type write and event in one cycle; gates may match (event dropped) or not.
   task automatic cfg_and_ev(int cg, logic c, logic i, int eg, int p, logic [1:0] nv, string tag);
      logic [1:0] e;
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_gate = GW'(cg);
      cfg_ctrl = c;
      cfg_inv = i;
      ev_valid = 1'b1;
      ev_gate = GW'(eg);
      ev_old = pins[eg][p];
      ev_new = nv;
      if (cg != eg) begin
         pins[eg][p] = nv;
         e = model_out(eg);
         push_exp(eg, e, e != mlast[eg], 1'b0, tag);
         mlast[eg] = e;
      end
      model_init(cg, c, i);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ev_valid = 1'b0;
         cfg_we = 1'b0;
      end
   endtask

   task automatic check_bit(bit ok, string tag, string what, int act, int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Monitor: compares every result against the scoreboard queue.
   always @(negedge clk) begin
      if (rst_n && !done && res_valid) begin
         if (expq.size() == 0) begin
            check_bit(0, "R8", "unexpected result gate", int'(res_gate), -1);
         end else begin
            exp_t  e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            vectors++;
            if (res_gate !== e.g || res_value !== e.v ||
                res_changed !== e.ch || res_illegal !== e.il) begin
               fails++;
               $display("FAIL %s actual gate=%0d val=%0d ch=%0d il=%0d expected gate=%0d val=%0d ch=%0d il=%0d",
                        t, res_gate, res_value, res_changed, res_illegal,
                        e.g, e.v, e.ch, e.il);
            end
         end
      end
   end

   initial begin
      #(4 * 190000);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      for (int g = 0; g < NG; g++) model_init(g, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit(res_valid == 1'b0, "R1", "res_valid after reset", int'(res_valid), 0);

      // R1: reset state is AND with all inputs unknown
      send_ev(0, 0, 2'b00, "R1 AND after reset, one input to 0");
      send_ev(0, 0, 2'b10, "R1 back to unknown");
      send_ev(1, 3, 2'b01, "R1 non-controlling 1 leaves output unknown");
      idle(2);

      // R2/R3/R4 for each gate type
      do_cfg(0, 1'b0, 1'b0);
      do_cfg(1, 1'b1, 1'b0);
      do_cfg(2, 1'b0, 1'b1);
      do_cfg(3, 1'b1, 1'b1);
      for (int g = 0; g < NG; g++) begin
         for (int p = 0; p < FI; p++)
            send_ev(g, p, {1'b0, ~mc[g]}, (p == FI - 1) ? "R4 all non-controlling" : "R3 unknowns remain");
         send_ev(g, 2, {1'b0, mc[g]}, "R2 one controlling input");
         send_ev(g, 5, {1'b0, mc[g]}, "R2 second controlling input");
         send_ev(g, 2, 2'b10, "R5 controlling to unknown, one c left");
         send_ev(g, 5, {1'b0, ~mc[g]}, "R3 controlling gone, unknown present");
         send_ev(g, 2, 2'b10, "R5 old equals new ignored");
         send_ev(g, 2, {1'b0, ~mc[g]}, "R4 unknown resolved");
         send_ev(g, 6, {1'b0, ~mc[g]}, "R7 no change when output stays");
      end
      idle(2);

      // R6: illegal codes
      send_bad(1, 2'b11, 2'b00, "R6 old code 11");
      send_bad(2, 2'b01, 2'b11, "R6 new code 11");
      send_ev(1, 0, {1'b0, mc[1]}, "R6 state untouched after illegal");
      send_bad(1, 2'b11, 2'b11, "R6 both codes 11");
      idle(2);

      // R9: type rewrite re-initialises; R10: other gates unaffected
      do_cfg(3, 1'b0, 1'b0);
      send_ev(3, 4, 2'b00, "R9 rewritten gate starts all unknown");
      cfg_and_ev(2, 1'b1, 1'b0, 2, 1, 2'b01, "R9 dropped");
      send_ev(2, 1, 2'b01, "R9 event after dropped one sees fresh gate");
      cfg_and_ev(0, 1'b1, 1'b1, 1, 7, 2'b10, "R10 event to other gate during write");
      send_ev(0, 0, 2'b01, "R10 rewritten gate 0 as NOR");
      send_ev(1, 7, {1'b0, mc[1]}, "R10 gate 1 kept its state");
      idle(2);

      // Random walk over all gates, back to back events
      lf = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
         int g, p, v;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         g = int'(lf[1:0]);
         p = int'(lf[4:2]) % FI;
         v = int'(lf[9:5]) % 3;
         if (lf[15:11] == 5'd7)
            send_bad(g, 2'b11, pins[g][p], "R6 random illegal");
         else if (lf[15:11] == 5'd9)
            do_cfg(g, lf[10], lf[11]);
         else
            send_ev(g, p, 2'(v), "R7 random walk");
         if (lf[15:12] == 4'd3) idle(1);
      end
      idle(3);
      check_bit(expq.size() == 0, "R8", "results outstanding", expq.size(), 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule